// File: doc/BRIEF.md
# Port-Decoded Expansion ROM and RAM Bank Controller

This block sits beside an 8-bit CPU and watches its I/O write cycles. It keeps a ROM page register and one RAM bank register per RAM block. A ROM page register selects one 16 KB page of a 512 KB flash. Each RAM bank register maps a 16 KB page of external RAM into the CPU window at 0x4000 to 0x7FFF. A port is decoded from single active-low upper address bits, not from the low port byte. When the host raises its own ROM or RAM select, the block takes over the access. It drives an override line that silences the host's internal memory and enables the external device instead.

The RAM side has a parameter for the number of 512 KB blocks. In the default build there are eight blocks, for 4 MB. Each block answers its own port, from 0x7Fxx down to 0x78xx. Each block holds its own bank and mapping mode. When more than one block maps a page at the same time, the block on the highest port wins. The set of ROM pages the board serves is a parameter mask. The default mask excludes pages 0 and 7, so the host keeps those ROMs.

Top module: `xbank_ctrl`

## Requirements
- R1: After reset, `rom_dis` and `ram_dis` are 0, `flash_ce_n` and `ram_ce_n` are 1, and `flash_hi` and `ram_hi` are 0, whatever the select strobes do.
- R2: A ROM page write is taken when `iorq_n`=0, `wr_n`=0, A15=1 and A13=0. A14 and the RAM port bits play no part in this decode. A write with A15=1 and A13=1 changes nothing.
- R3: One clock after the first cycle in which a ROM page write is sampled, `flash_hi` shows bits 4:0 of the byte written.
- R4: `rom_dis`=1 and `flash_ce_n`=0 exactly when three things hold: `rom_sel_n`=0, a ROM write has happened since reset, and the latched byte is below 32 with its bit set in the serve mask. The default mask serves every page except 0 and 7.
- R5: Cycles with `wr_n`=1 (I/O reads) change no register, even when the port bits match.
- R6: A write with `iorq_n`=0, `wr_n`=0 and A15=0 goes to the RAM port of block ~A10:8, so 0x7F is block 0 and 0x78 is block 7. The byte counts only when bits 7:6 are 11. In that case bits 5:3 become the block's bank and bits 2:0 its mode. Any other top bits leave every register unchanged.
- R7: `ram_dis`=1 and `ram_ce_n`=0 exactly when three things hold: `ram_sel_n`=0, A15:A14=01, and some block has a mode of 4 to 7. Modes 0 to 3 never map a page.
- R8: `ram_hi` is {block index, bank, mode bits 1:0} of the winning block, 8 bits wide. When no block maps a page, block 0 is shown.
- R9: When several blocks map a page, the lowest block index wins. Each block keeps its own value while another block wins or is written.
- R10: A write strobe held for several cycles is taken once, in its first sampled cycle. A data change later in the same strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the CPU bus is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cpu_a15_13 | input | 3 | CPU address bits A15, A14, A13 |
| cpu_a10_8 | input | 3 | CPU address bits A10, A9, A8 (RAM block port) |
| cpu_data | input | 8 | CPU data bus, read only |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_sel_n | input | 1 | Host ROM select, active low |
| ram_sel_n | input | 1 | Host RAM select, active low |
| flash_hi | output | 5 | Flash page address lines |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| rom_dis | output | 1 | Override that silences internal ROM, active high |
| ram_hi | output | 8 | External RAM page address lines |
| ram_ce_n | output | 1 | External RAM chip enable, active low |
| ram_dis | output | 1 | Override that silences internal RAM, active high |

## Verification
The bench targets the decode corners. One case is an address with A15=0 and A13=0: a decoder that ignored A15 would change the ROM page. Another is ROM numbers 0, 7 and values of 32 and above: a wrong serve test would silence the host ROM. RAM bytes whose top bits are not 11, and modes 1 to 3, must leave the override low. Several blocks map at once, then the winning block is cleared: a design that lost its per-block state, or chose the wrong priority, would put the wrong page on `ram_hi`. A long strobe whose data changes part-way through catches a decoder that latches on every cycle of the strobe.

// File: rtl/xbank_pkg.sv
package xbank_pkg;

    // mode[2] set means a page is mapped in the 0x4000-0x7FFF window
    typedef struct packed {
        logic [2:0] bank;
        logic [2:0] mode;
    } ram_cfg_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] num;
    } rom_st_t;

    typedef struct packed {
        logic strobe;
    } snoop_st_t;

    localparam logic [1:0] BANK_WR_TAG = 2'b11;
    localparam logic [1:0] WINDOW_A15_14 = 2'b01;

endpackage

// File: rtl/xbank_io_snoop.sv
module xbank_io_snoop
    import xbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a15,
    input  logic       a13,
    input  logic       iorq_n,
    input  logic       wr_n,
    output logic       wr_rom,
    output logic       wr_ram
);

    snoop_st_t st_d, st_q;
    logic      strobe;
    logic      go;

    always_comb begin
        strobe      = ~iorq_n & ~wr_n;
        st_d        = st_q;
        st_d.strobe = strobe;
        // take the write only in the first sampled cycle of the strobe
        go          = strobe & ~st_q.strobe;
        wr_rom      = go & a15 & ~a13;
        wr_ram      = go & ~a15;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rom || wr_ram) |=> !(wr_rom || wr_ram)); // R10

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |-> !(wr_rom || wr_ram)); // R5

endmodule

// File: rtl/xbank_rom_pager.sv
module xbank_rom_pager
    import xbank_pkg::*;
#(
    parameter int PAGE_W = 5,
    parameter logic [2**PAGE_W-1:0] SERVE_MASK = 32'hFFFF_FF7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rom,
    input  logic [7:0]        wr_data,
    input  logic              rom_sel_n,
    output logic [PAGE_W-1:0] flash_hi,
    output logic              flash_ce_n,
    output logic              rom_dis
);

    rom_st_t st_d, st_q;
    logic    in_range;
    logic    served;

    always_comb begin
        st_d = st_q;
        if (wr_rom) begin
            st_d.valid = 1'b1;
            st_d.num   = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        in_range   = (st_q.num[7:PAGE_W] == '0);
        served     = st_q.valid & in_range & SERVE_MASK[st_q.num[PAGE_W-1:0]];
        rom_dis    = served & ~rom_sel_n;
        flash_ce_n = ~rom_dis;
        flash_hi   = st_q.num[PAGE_W-1:0];
    end

    AST_ROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rom |=> (flash_hi == $past(wr_data[PAGE_W-1:0]))); // R3

    AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rom |=> $stable(st_q)); // R5

    AST_ROMDIS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_dis |-> (!rom_sel_n && st_q.valid)); // R4

    AST_ROM_EXCLUDE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_dis |-> SERVE_MASK[flash_hi]); // R4

endmodule

// File: rtl/xbank_ram_pager.sv
module xbank_ram_pager
    import xbank_pkg::*;
#(
    parameter int RAM_BLOCKS = 8,
    localparam int IDX_W = (RAM_BLOCKS > 1) ? $clog2(RAM_BLOCKS) : 1,
    localparam int HI_W  = IDX_W + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ram,
    input  logic [7:0]      wr_data,
    input  logic [2:0]      wr_port,
    input  logic [1:0]      a15_14,
    input  logic            ram_sel_n,
    output logic [HI_W-1:0] ram_hi,
    output logic            ram_ce_n,
    output logic            ram_dis
);

    typedef struct packed {
        ram_cfg_t [RAM_BLOCKS-1:0] cfg;
    } ram_st_t;

    ram_st_t          st_d, st_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] sel;
    logic             any_map;
    logic             bank_wr;
    ram_cfg_t         sel_cfg;

    generate
        if (RAM_BLOCKS > 1) begin : g_multi
            // highest port (all ones) is block 0
            assign wr_idx = ~wr_port[IDX_W-1:0];
        end else begin : g_single
            logic [2:0] port_unused;
            assign port_unused = wr_port;
            assign wr_idx      = '0;
        end
    endgenerate

    always_comb begin
        bank_wr = wr_ram & (wr_data[7:6] == BANK_WR_TAG);
        st_d    = st_q;
        if (bank_wr) begin
            st_d.cfg[wr_idx] = ram_cfg_t'(wr_data[5:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // lowest mapping block index wins
    always_comb begin
        sel     = '0;
        any_map = 1'b0;
        for (int i = RAM_BLOCKS - 1; i >= 0; i--) begin
            if (st_q.cfg[i].mode[2]) begin
                sel     = IDX_W'(i);
                any_map = 1'b1;
            end
        end
        sel_cfg  = st_q.cfg[sel];
        ram_dis  = any_map & ~ram_sel_n & (a15_14 == WINDOW_A15_14);
        ram_ce_n = ~ram_dis;
        ram_hi   = {sel, sel_cfg.bank, sel_cfg.mode[1:0]};
    end

    AST_RAM_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ram && wr_data[7:6] != BANK_WR_TAG) |=> $stable(st_q)); // R6

    AST_RAM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> (st_q.cfg[$past(wr_idx)] == $past(wr_data[5:0]))); // R6

    AST_RAMDIS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dis |-> (a15_14 == WINDOW_A15_14 && !ram_sel_n)); // R7

    AST_RAMDIS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dis |-> sel_cfg.mode[2]); // R7

endmodule

// File: rtl/xbank_ctrl.sv
module xbank_ctrl
    import xbank_pkg::*;
#(
    parameter int RAM_BLOCKS = 8,
    parameter int ROM_PAGE_W = 5,
    parameter logic [2**ROM_PAGE_W-1:0] ROM_SERVE_MASK = 32'hFFFF_FF7E,
    localparam int RAM_IDX_W = (RAM_BLOCKS > 1) ? $clog2(RAM_BLOCKS) : 1,
    localparam int RAM_HI_W  = RAM_IDX_W + 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            cpu_a15_13,
    input  logic [2:0]            cpu_a10_8,
    input  logic [7:0]            cpu_data,
    input  logic                  iorq_n,
    input  logic                  wr_n,
    input  logic                  rom_sel_n,
    input  logic                  ram_sel_n,
    output logic [ROM_PAGE_W-1:0] flash_hi,
    output logic                  flash_ce_n,
    output logic                  rom_dis,
    output logic [RAM_HI_W-1:0]   ram_hi,
    output logic                  ram_ce_n,
    output logic                  ram_dis
);

    logic wr_rom;
    logic wr_ram;

    xbank_io_snoop u_snoop (
        .clk    (clk),
        .rst_n  (rst_n),
        .a15    (cpu_a15_13[2]),
        .a13    (cpu_a15_13[0]),
        .iorq_n (iorq_n),
        .wr_n   (wr_n),
        .wr_rom (wr_rom),
        .wr_ram (wr_ram)
    );

    xbank_rom_pager #(
        .PAGE_W     (ROM_PAGE_W),
        .SERVE_MASK (ROM_SERVE_MASK)
    ) u_rom (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_rom     (wr_rom),
        .wr_data    (cpu_data),
        .rom_sel_n  (rom_sel_n),
        .flash_hi   (flash_hi),
        .flash_ce_n (flash_ce_n),
        .rom_dis    (rom_dis)
    );

    xbank_ram_pager #(
        .RAM_BLOCKS (RAM_BLOCKS)
    ) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ram    (wr_ram),
        .wr_data   (cpu_data),
        .wr_port   (cpu_a10_8),
        .a15_14    (cpu_a15_13[2:1]),
        .ram_sel_n (ram_sel_n),
        .ram_hi    (ram_hi),
        .ram_ce_n  (ram_ce_n),
        .ram_dis   (ram_dis)
    );

    AST_NO_DOUBLE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_rom && wr_ram)); // R2

endmodule

// File: tb/xbank_ctrl_tb.sv
`timescale 1ns/1ps
module xbank_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_a15_13 = 3'b111;
    logic [2:0] cpu_a10_8 = 3'b111;
    logic [7:0] cpu_data = 8'h00;
    logic       iorq_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       rom_sel_n = 1'b1;
    logic       ram_sel_n = 1'b1;
    logic [4:0] flash_hi;
    logic       flash_ce_n;
    logic       rom_dis;
    logic [7:0] ram_hi;
    logic       ram_ce_n;
    logic       ram_dis;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xbank_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_a15_13 (cpu_a15_13),
        .cpu_a10_8  (cpu_a10_8),
        .cpu_data   (cpu_data),
        .iorq_n     (iorq_n),
        .wr_n       (wr_n),
        .rom_sel_n  (rom_sel_n),
        .ram_sel_n  (ram_sel_n),
        .flash_hi   (flash_hi),
        .flash_ce_n (flash_ce_n),
        .rom_dis    (rom_dis),
        .ram_hi     (ram_hi),
        .ram_ce_n   (ram_ce_n),
        .ram_dis    (ram_dis)
    );

    // {addr[15:0], data, exp flash_hi, exp rom_dis, exp ram_dis, exp ram_hi}
    localparam int NV = 16;
    localparam logic [38:0] VEC [NV] = '{
        {16'hDF00, 8'h05, 5'h05, 1'b1, 1'b0, 8'h00},  // R4 served page
        {16'hDF00, 8'h07, 5'h07, 1'b0, 1'b0, 8'h00},  // R4 page 7 excluded
        {16'hDF00, 8'h00, 5'h00, 1'b0, 1'b0, 8'h00},  // R4 page 0 excluded
        {16'hDFAA, 8'h1F, 5'h1F, 1'b1, 1'b0, 8'h00},  // R2 low byte free
        {16'hDF00, 8'h25, 5'h05, 1'b0, 1'b0, 8'h00},  // R4 value >= 32
        {16'h7F00, 8'hC4, 5'h05, 1'b0, 1'b1, 8'h00},  // R6 block0 bank0 mode4
        {16'h7F12, 8'hD6, 5'h05, 1'b0, 1'b1, 8'h0A},  // R8 bank2 page2
        {16'h7C00, 8'hFD, 5'h05, 1'b0, 1'b1, 8'h0A},  // R9 block0 wins over 3
        {16'h7F00, 8'hC0, 5'h05, 1'b0, 1'b1, 8'h7D},  // R9 block3 kept its value
        {16'h7F00, 8'h3F, 5'h05, 1'b0, 1'b1, 8'h7D},  // R6 top bits 00 ignored
        {16'h7800, 8'hE9, 5'h05, 1'b0, 1'b1, 8'h7D},  // R7 mode1 maps nothing
        {16'h7C00, 8'hC3, 5'h05, 1'b0, 1'b0, 8'h00},  // R7 mode3, none map
        {16'h7800, 8'hEF, 5'h05, 1'b0, 1'b1, 8'hF7},  // R8 block7 bank5 page3
        {16'h5F00, 8'h02, 5'h05, 1'b0, 1'b1, 8'hF7},  // R2 A15=0 not ROM
        {16'hBF00, 8'h06, 5'h05, 1'b0, 1'b1, 8'hF7},  // R2 A13=1 no port
        {16'h9F00, 8'h06, 5'h06, 1'b1, 1'b1, 8'hF7}   // R2 A14 ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_addr(input logic [15:0] a);
        cpu_a15_13 = a[15:13];
        cpu_a10_8  = a[10:8];
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d, input int hold = 1);
        @(negedge clk);
        set_addr(a);
        cpu_data = d;
        iorq_n   = 1'b0;
        wr_n     = 1'b0;
        repeat (hold) @(negedge clk);
        iorq_n = 1'b1;
        wr_n   = 1'b1;
        @(negedge clk);
    endtask

    task automatic probe(input logic [15:0] a, input logic rs, input logic ms);
        @(negedge clk);
        set_addr(a);
        rom_sel_n = rs;
        ram_sel_n = ms;
        #1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state with both selects active
        probe(16'h4000, 1'b0, 1'b0);
        chk("R1 rom_dis", rom_dis, 0);
        chk("R1 flash_ce_n", flash_ce_n, 1);
        chk("R1 ram_dis", ram_dis, 0);
        chk("R1 ram_ce_n", ram_ce_n, 1);
        @(negedge clk);
        rst_n = 1'b1;
        probe(16'h4000, 1'b0, 1'b0);
        chk("R1 flash_hi", flash_hi, 0);
        chk("R1 ram_hi", ram_hi, 0);
        chk("R1 rom_dis after release", rom_dis, 0);

        // vector walk: R2 R3 R4 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            io_wr(VEC[i][38:23], VEC[i][22:15]);
            probe(16'h4000, 1'b0, 1'b0);
            chk($sformatf("R3 vec%0d flash_hi", i), flash_hi, VEC[i][14:10]);
            chk($sformatf("R4 vec%0d rom_dis", i), rom_dis, VEC[i][9]);
            chk($sformatf("R4 vec%0d flash_ce_n", i), flash_ce_n, !VEC[i][9]);
            chk($sformatf("R7 vec%0d ram_dis", i), ram_dis, VEC[i][8]);
            chk($sformatf("R8 vec%0d ram_hi", i), ram_hi, VEC[i][7:0]);
        end

        // R7: outside window or strobe high
        probe(16'h8000, 1'b0, 1'b0);
        chk("R7 addr 0x8000", ram_dis, 0);
        probe(16'h3FFF, 1'b0, 1'b0);
        chk("R7 addr 0x3FFF", ram_dis, 0);
        probe(16'h4000, 1'b1, 1'b1);
        chk("R7 ram_sel_n high", ram_dis, 0);
        chk("R7 ram_ce_n idle", ram_ce_n, 1);
        chk("R4 rom_sel_n high", rom_dis, 0);
        chk("R4 flash_ce_n idle", flash_ce_n, 1);

        // R5: read cycle on ROM and RAM ports changes nothing
        @(negedge clk);
        set_addr(16'hDF00);
        cpu_data = 8'h03;
        iorq_n = 1'b0;
        wr_n = 1'b1;
        @(negedge clk);
        set_addr(16'h7F00);
        cpu_data = 8'hC4;
        @(negedge clk);
        iorq_n = 1'b1;
        probe(16'h4000, 1'b0, 1'b0);
        chk("R5 flash_hi after read", flash_hi, 5'h06);
        chk("R5 ram_hi after read", ram_hi, 8'hF7);

        // R10: long strobe, data changes mid-way
        @(negedge clk);
        set_addr(16'hDF00);
        cpu_data = 8'h09;
        iorq_n = 1'b0;
        wr_n = 1'b0;
        @(negedge clk);
        cpu_data = 8'h0A;
        repeat (2) @(negedge clk);
        iorq_n = 1'b1;
        wr_n = 1'b1;
        probe(16'h4000, 1'b0, 1'b0);
        chk("R10 first data kept", flash_hi, 5'h09);
        chk("R10 rom_dis", rom_dis, 1);

        // R1: reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        probe(16'h4000, 1'b0, 1'b0);
        chk("R1 rerst flash_hi", flash_hi, 0);
        chk("R1 rerst rom_dis", rom_dis, 0);
        chk("R1 rerst ram_dis", ram_dis, 0);
        chk("R1 rerst ram_hi", ram_hi, 0);
        @(negedge clk);
        rst_n = 1'b1;

        summary();
        $finish;
    end

endmodule